// File: doc/BRIEF.md
# Basic Up-Counting Timer with Update Control

A 16-bit timer that counts upward from zero. A programmable prescaler sets the pace of the count. When the count reaches a reload value, it wraps back to zero. Each wrap, each software update request and each pulse on the slave-reset input can produce an update event. On an update event the buffered prescaler value and the buffered reload value move into the working (shadow) copies. An update event can also raise a status flag, which feeds an interrupt line and a DMA request line through separate enable bits.

Software reaches the timer through a simple register port with a write side and a separate combinational read side. Registers are 16 bits wide and sit on word-aligned byte addresses. A 32-bit access carries the register in bits 15:0. A half-word access carries it at the word's base address. The control register chooses the following:
- whether the reload value is buffered;
- whether the timer stops after one period;
- whether update requests from software or from the slave input reach the flag;
- whether update events are suppressed.

Register map (byte addresses): 0x00 control, 0x04 request enables, 0x08 status, 0x0C update generation, 0x10 counter, 0x14 prescaler, 0x18 reload.

Top module: `basic_up_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the counter reads 0, the prescaler reads 0 and the reload reads 0xFFFF. Control bits 15:8 and 6:4 always read 0, so writing all ones reads back 0x008F.
- R2: Control bit 0 enables counting. While it is 0, the counter and the prescaler hold their values. While it is 1, the counter advances once per prescaler period.
- R3: On a prescaler tick at which the counter equals the active reload value, the counter goes to 0 on that tick. This is an overflow, and it produces an update event unless updates are disabled.
- R4: The prescaler period is the shadow prescaler value plus 1 clock cycles. A write to the prescaler register (0x14) changes only the preload. The shadow takes the preload value, as it stood before that cycle's write, on an update event.
- R5: Control bit 7 selects reload buffering. When it is 0, the reload register (0x18) is the active reload. When it is 1, the shadow is active, and the shadow takes the reload preload (as it stood before that cycle's write) on an update event.
- R6: Control bit 3 selects one-pulse operation. When it is 1, an update event clears control bit 0. This hardware clear wins over a software write in the same cycle.
- R7: Control bit 2 selects the request source. When it is 0, every update event sets the status flag (status bit 0). When it is 1, only an overflow sets the flag, although software and slave updates still load the shadows.
- R8: Control bit 1 disables updates. While it is 1, no update event occurs, the shadows keep their values and the flag is not set. An overflow still wraps the counter to 0, and a software or slave update still clears the counter and the prescaler.
- R9: Writing status bit 0 as 0 clears the flag, and writing it as 1 has no effect. Setting the flag wins over clearing it. irq equals the flag AND enable bit 0 (0x04), and dma equals the flag AND enable bit 1.
- R10: A write whose address has bits 1:0 nonzero is ignored, and a read at such an address returns 0. A 32-bit write uses data bits 15:0 only.
- R11: A one-cycle pulse on slaveReset clears the counter and the prescaler at the next edge. It acts as an update source in the same way as the software update bit.
- R12: Writing 1 to bit 0 of the update-generation register (0x0C) clears the counter and the prescaler and requests an update. The register always reads 0. A software write to the counter loses to a software or slave update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 5 | Write byte address |
| wrData | input | 32 | Write data; bits 15:0 carry the register |
| rdAddr | input | 5 | Read byte address |
| rdData | output | 32 | Combinational read data |
| slaveReset | input | 1 | Slave-controller reset and update pulse |
| irq | output | 1 | Update interrupt |
| dma | output | 1 | Update DMA request |

## Verification
Each fault shows at the ports within a bounded time:
- **Prescaler shadow loaded wrongly.** The counter readback drifts from its expected value within one prescaler period.
- **Reload shadow loaded wrongly.** The counter reads a value past the reload, or wraps early, within one counting period.
- **Status flag set or cleared wrongly.** irq or dma differs one clock after the event that caused the error.
- **One-pulse clear missing.** The control readback shows bit 0 still set immediately after the update, and the counter keeps moving.

A bench model built from the requirements is compared with irq and dma on every cycle and with register readbacks after every operation. Mixed in are directed cases for:
- the reserved bits;
- address handling;
- the request source with updates disabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register slots; byte address = slot * 4.
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_IEN  = 3'd1,
    REG_STAT = 3'd2,
    REG_EGEN = 3'd3,
    REG_CNT  = 3'd4,
    REG_PSC  = 3'd5,
    REG_RLD  = 3'd6
  } regIdx_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic cntWr;       // software write to counter
    logic pscWr;       // software write to prescaler preload
    logic rldWr;       // software write to reload preload
    logic reinit;      // clear counter and prescaler
    logic shadowLoad;  // update event: copy preloads to shadows
  } dpStrobe_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         tick
);

  assign tick = run && (count == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (run) begin
      count <= tick ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             runEn,
  input  logic             bufRld,
  input  logic [CNT_W-1:0] wrVal,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] psCnt,
  output logic [CNT_W-1:0] arrPre,
  output logic [CNT_W-1:0] arrShadow,
  output logic [CNT_W-1:0] pscPre,
  output logic [CNT_W-1:0] pscShadow,
  output logic             ovf
);

  logic             tick;
  logic [CNT_W-1:0] reloadNow;

  tmr_prescaler #(.W(CNT_W)) u_psc (
    .clk   (clk),
    .rstN  (rstN),
    .run   (runEn),
    .clear (stb.reinit),
    .limit (pscShadow),
    .count (psCnt),
    .tick  (tick)
  );

  assign reloadNow = bufRld ? arrShadow : arrPre;
  assign ovf       = tick && (cnt == reloadNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.reinit) begin
      cnt <= '0;
    end else if (stb.cntWr) begin
      cnt <= wrVal;
    end else if (tick) begin
      cnt <= ovf ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrPre    <= '1;
      arrShadow <= '1;
      pscPre    <= '0;
      pscShadow <= '0;
    end else begin
      if (stb.rldWr) arrPre <= wrVal;
      if (stb.pscWr) pscPre <= wrVal;
      if (stb.shadowLoad) begin
        arrShadow <= arrPre;
        pscShadow <= pscPre;
      end
    end
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrLow,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              slaveReset,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  arrPre,
  input  logic [CNT_W-1:0]  pscPre,
  output dpStrobe_t         stb,
  output logic              uev,
  output logic              runQ,
  output logic              oneShotQ,
  output logic              ovfOnlyQ,
  output logic              updOffQ,
  output logic              bufRldQ,
  output logic              flagQ,
  output logic              irq,
  output logic              dma
);

  localparam int IDX_W = ADDR_W - 2;

  function automatic logic regHit(input logic [ADDR_W-1:0] a, input regIdx_e r);
    return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] == IDX_W'(r));
  endfunction

  logic wrCtrl, wrIen, wrStat, swUpdate, reinit, req;
  logic irqEnQ, dmaEnQ;

  assign wrCtrl   = wrEn && regHit(wrAddr, REG_CTRL);
  assign wrIen    = wrEn && regHit(wrAddr, REG_IEN);
  assign wrStat   = wrEn && regHit(wrAddr, REG_STAT);
  assign swUpdate = wrEn && regHit(wrAddr, REG_EGEN) && wrLow[0];
  assign reinit   = swUpdate || slaveReset;
  assign uev      = (ovf || reinit) && !updOffQ;
  assign req      = uev && (ovf || !ovfOnlyQ);

  always_comb begin
    stb            = '0;
    stb.cntWr      = wrEn && regHit(wrAddr, REG_CNT);
    stb.pscWr      = wrEn && regHit(wrAddr, REG_PSC);
    stb.rldWr      = wrEn && regHit(wrAddr, REG_RLD);
    stb.reinit     = reinit;
    stb.shadowLoad = uev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      updOffQ  <= 1'b0;
      ovfOnlyQ <= 1'b0;
      oneShotQ <= 1'b0;
      bufRldQ  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runQ     <= wrLow[0];
        updOffQ  <= wrLow[1];
        ovfOnlyQ <= wrLow[2];
        oneShotQ <= wrLow[3];
        bufRldQ  <= wrLow[7];
      end
      if (uev && oneShotQ) runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      irqEnQ <= 1'b0;
      dmaEnQ <= 1'b0;
    end else begin
      if (req) flagQ <= 1'b1;
      else if (wrStat && !wrLow[0]) flagQ <= 1'b0;
      if (wrIen) begin
        irqEnQ <= wrLow[0];
        dmaEnQ <= wrLow[1];
      end
    end
  end

  assign irq = flagQ && irqEnQ;
  assign dma = flagQ && dmaEnQ;

  always_comb begin
    rdData = '0;
    if (regHit(rdAddr, REG_CTRL))
      rdData[7:0] = {bufRldQ, 3'b000, oneShotQ, ovfOnlyQ, updOffQ, runQ};
    else if (regHit(rdAddr, REG_IEN))
      rdData[1:0] = {dmaEnQ, irqEnQ};
    else if (regHit(rdAddr, REG_STAT))
      rdData[0] = flagQ;
    else if (regHit(rdAddr, REG_CNT))
      rdData[CNT_W-1:0] = cnt;
    else if (regHit(rdAddr, REG_PSC))
      rdData[CNT_W-1:0] = pscPre;
    else if (regHit(rdAddr, REG_RLD))
      rdData[CNT_W-1:0] = arrPre;
  end

endmodule

// File: rtl/basic_up_timer.sv
module basic_up_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              slaveReset,
  output logic              irq,
  output logic              dma
);

  dpStrobe_t        stb;
  logic             uev, ovf;
  logic             runQ, oneShotQ, ovfOnlyQ, updOffQ, bufRldQ, flagQ;
  logic [CNT_W-1:0] cnt, psCnt, arrPre, arrShadow, pscPre, pscShadow;
  logic             unusedHi;

  assign unusedHi = ^wrData[31:CNT_W];

  tmr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrLow      (wrData[7:0]),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .slaveReset (slaveReset),
    .ovf        (ovf),
    .cnt        (cnt),
    .arrPre     (arrPre),
    .pscPre     (pscPre),
    .stb        (stb),
    .uev        (uev),
    .runQ       (runQ),
    .oneShotQ   (oneShotQ),
    .ovfOnlyQ   (ovfOnlyQ),
    .updOffQ    (updOffQ),
    .bufRldQ    (bufRldQ),
    .flagQ      (flagQ),
    .irq        (irq),
    .dma        (dma)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .runEn     (runQ),
    .bufRld    (bufRldQ),
    .wrVal     (wrData[CNT_W-1:0]),
    .cnt       (cnt),
    .psCnt     (psCnt),
    .arrPre    (arrPre),
    .arrShadow (arrShadow),
    .pscPre    (pscPre),
    .pscShadow (pscShadow),
    .ovf       (ovf)
  );

endmodule

// File: rtl/basic_up_timer_chk.sv
module basic_up_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic              slaveReset,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  psCnt,
  input logic [CNT_W-1:0]  arrShadow,
  input logic [CNT_W-1:0]  pscShadow,
  input logic              ovf,
  input logic              uev,
  input logic              reinit,
  input logic              cntWr,
  input logic              runQ,
  input logic              oneShotQ,
  input logic              ovfOnlyQ,
  input logic              updOffQ,
  input logic              flagQ
);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(0)) |-> (rdData[31:8] == '0 && rdData[6:4] == 3'b000));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !reinit && !cntWr) |=> $stable(cnt));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !reinit && !cntWr) |=> (cnt == '0));

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (uev && oneShotQ) |=> !runQ);

  p_src_select_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfOnlyQ && !ovf && !flagQ) |=> !flagQ);

  p_frozen_shadow_r8: assert property (@(posedge clk) disable iff (!rstN)
    updOffQ |=> ($stable(arrShadow) && $stable(pscShadow)));

  p_slave_reinit_r11: assert property (@(posedge clk) disable iff (!rstN)
    slaveReset |=> (cnt == '0 && psCnt == '0));

  p_egen_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(12)) |-> (rdData == '0));

endmodule

bind basic_up_timer basic_up_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .slaveReset (slaveReset),
  .cnt        (cnt),
  .psCnt      (psCnt),
  .arrShadow  (arrShadow),
  .pscShadow  (pscShadow),
  .ovf        (ovf),
  .uev        (uev),
  .reinit     (stb.reinit),
  .cntWr      (stb.cntWr),
  .runQ       (runQ),
  .oneShotQ   (oneShotQ),
  .ovfOnlyQ   (ovfOnlyQ),
  .updOffQ    (updOffQ),
  .flagQ      (flagQ)
);

// File: tb/basic_up_timer_test.sv
module basic_up_timer_test;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, slaveReset = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              irq, dma;
  int                checks = 0, fails = 0;
  bit                live = 1'b0;

  always #5 clk = ~clk;

  basic_up_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .slaveReset(slaveReset), .irq(irq), .dma(dma)
  );

  // Reference model, written from the requirements
  logic        mRun, mUpdOff, mOvfOnly, mOneShot, mBuf, mFlag, mIe, mDe;
  logic [15:0] mCnt, mPs, mArrPre, mArrSh, mPscPre, mPscSh;
  logic        hC, hI, hS, hN, hP, hR, ug, rein, tk, ov, ev, rq, nRun;
  logic [15:0] eff;

  always @(posedge clk) begin
    if (!rstN) begin
      {mRun, mUpdOff, mOvfOnly, mOneShot, mBuf, mFlag, mIe, mDe} = '0;
      mCnt = '0; mPs = '0; mArrPre = 16'hFFFF; mArrSh = 16'hFFFF; mPscPre = '0; mPscSh = '0;
    end else begin
      hC   = wrEn && wrAddr == 5'h00;
      hI   = wrEn && wrAddr == 5'h04;
      hS   = wrEn && wrAddr == 5'h08;
      ug   = wrEn && wrAddr == 5'h0C && wrData[0];
      hN   = wrEn && wrAddr == 5'h10;
      hP   = wrEn && wrAddr == 5'h14;
      hR   = wrEn && wrAddr == 5'h18;
      rein = ug || slaveReset;
      tk   = mRun && (mPs == mPscSh);
      eff  = mBuf ? mArrSh : mArrPre;
      ov   = tk && (mCnt == eff);
      ev   = (ov || rein) && !mUpdOff;
      rq   = ev && (ov || !mOvfOnly);
      nRun = hC ? wrData[0] : mRun;
      if (ev && mOneShot) nRun = 1'b0;
      if (rein) mPs = '0; else if (mRun) mPs = tk ? 16'h0 : mPs + 16'h1;
      if (rein) mCnt = '0; else if (hN) mCnt = wrData[15:0];
      else if (tk) mCnt = ov ? 16'h0 : mCnt + 16'h1;
      if (ev) begin mArrSh = mArrPre; mPscSh = mPscPre; end
      if (hR) mArrPre = wrData[15:0];
      if (hP) mPscPre = wrData[15:0];
      if (rq) mFlag = 1'b1; else if (hS && !wrData[0]) mFlag = 1'b0;
      if (hI) begin mIe = wrData[0]; mDe = wrData[1]; end
      if (hC) begin
        mUpdOff = wrData[1]; mOvfOnly = wrData[2]; mOneShot = wrData[3]; mBuf = wrData[7];
      end
      mRun = nRun;
    end
  end

  function automatic logic [31:0] mRead(input int idx);
    case (idx)
      0: return {24'h0, mBuf, 3'b000, mOneShot, mOvfOnly, mUpdOff, mRun};
      1: return {30'h0, mDe, mIe};
      2: return {31'h0, mFlag};
      4: return {16'h0, mCnt};
      5: return {16'h0, mPscPre};
      6: return {16'h0, mArrPre};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slv();
    slaveReset = 1'b1;
    @(negedge clk);
    slaveReset = 1'b0;
  endtask

  task automatic rdHand(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    rdAddr = a; #1;
    check(tag, rdData, exp);
  endtask

  task automatic rdModel(input string tag, input int idx);
    rdAddr = ADDR_W'(idx * 4); #1;
    check(tag, rdData, mRead(idx));
  endtask

  // Interrupt and DMA outputs against the model each cycle (R9)
  always @(negedge clk) begin
    if (live) begin
      check("R9 irq", {31'h0, irq}, {31'h0, mFlag && mIe});
      check("R9 dma", {31'h0, dma}, {31'h0, mFlag && mDe});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    string tags[7];
    tags = '{"R6 ctrl", "R9 ien", "R7 stat", "R12 egen", "R3 cnt", "R4 psc", "R5 rld"};
    void'($urandom(32'd4711));
    idle(3);
    rstN = 1'b1;
    live = 1'b1;
    // R1 reset values and reserved bits
    rdHand("R1 ctrl reset", 5'h00, 32'h0);
    rdHand("R1 cnt reset", 5'h10, 32'h0);
    rdHand("R1 psc reset", 5'h14, 32'h0);
    rdHand("R1 rld reset", 5'h18, 32'h0000FFFF);
    wr(5'h00, 32'hFFFF_FFFF);
    rdHand("R1 reserved bits", 5'h00, 32'h0000008F);
    wr(5'h00, 32'h0);
    // R10 address alignment and width
    wr(5'h02, 32'h1);
    rdHand("R10 upper half ignored", 5'h00, 32'h0);
    rdHand("R10 unaligned read", 5'h02, 32'h0);
    wr(5'h14, 32'hFFFF_0002);
    rdHand("R10 wide write low half", 5'h14, 32'h2);
    // R12 software update, R7 flag with source select 0
    wr(5'h0C, 32'h1);
    rdHand("R12 egen reads 0", 5'h0C, 32'h0);
    rdHand("R12 cnt cleared", 5'h10, 32'h0);
    rdHand("R7 flag on software update", 5'h08, 32'h1);
    // R9 flag clearing and gating
    wr(5'h04, 32'h3);
    check("R9 irq on", {31'h0, irq}, 32'h1);
    check("R9 dma on", {31'h0, dma}, 32'h1);
    wr(5'h08, 32'h1);
    rdHand("R9 write 1 keeps flag", 5'h08, 32'h1);
    wr(5'h08, 32'h0);
    rdHand("R9 write 0 clears", 5'h08, 32'h0);
    wr(5'h04, 32'h1);
    // R2 and R4 counting pace with prescaler 2
    wr(5'h18, 32'h5);
    wr(5'h00, 32'h1);
    idle(7);
    rdHand("R4 pace div3", 5'h10, 32'h2);
    rdModel("R2 counting", 4);
    wr(5'h14, 32'h0);
    idle(6);
    rdModel("R4 preload not yet active", 4);
    // R3 wrap and flag
    idle(30);
    rdModel("R3 wrap cnt", 4);
    rdModel("R3 flag", 2);
    // R5 buffered reload
    wr(5'h00, 32'h81);
    wr(5'h18, 32'h7);
    rdModel("R5 rld preload", 6);
    idle(3);
    rdModel("R5 old reload active", 4);
    idle(40);
    rdModel("R5 new reload", 4);
    // R6 one-pulse
    wr(5'h00, 32'h09);
    idle(60);
    rdModel("R6 stopped", 0);
    rdModel("R6 cnt held", 4);
    // R8 update disable
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h03);
    wr(5'h14, 32'h3);
    idle(20);
    rdModel("R8 no flag", 2);
    wr(5'h0C, 32'h1);
    rdHand("R8 reinit still clears", 5'h10, 32'h0);
    idle(10);
    rdModel("R8 shadow frozen pace", 4);
    // R7 overflow-only source
    wr(5'h00, 32'h05);
    wr(5'h0C, 32'h1);
    rdHand("R7 software update blocked", 5'h08, 32'h0);
    idle(5);
    // R11 slave reset
    slv();
    rdHand("R11 slave clears cnt", 5'h10, 32'h0);
    idle(9);
    rdModel("R11 pace after slave update", 4);
    // R12 counter write loses to update
    wr(5'h00, 32'h01);
    wrAddr = 5'h10; wrData = 32'h3; wrEn = 1'b1; slaveReset = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; slaveReset = 1'b0;
    rdHand("R12 update beats cnt write", 5'h10, 32'h0);
    // Random phase
    for (int i = 0; i < 2500; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 11);
      d = $urandom;
      case (op)
        0: begin
          d[0] = ($urandom % 4) != 0;
          d[1] = ($urandom % 4) == 0;
          d[3] = ($urandom % 4) == 0;
          wr(5'h00, d);
        end
        1: wr(5'h14, d & 32'hFFFF_0003 % 32'h3);
        2: wr(5'h18, 32'h4 + ($urandom % 4));
        3: wr(5'h10, $urandom % 4);
        4: wr(5'h0C, d);
        5: slv();
        6: wr(5'h08, d);
        7: wr(5'h04, d);
        8: idle(1 + int'($urandom % 6));
        9: wr(5'h16, d);
        default: wr(5'h1C, d);
      endcase
      begin
        int k;
        k = int'($urandom % 7);
        rdModel(tags[k], k);
      end
    end
    live = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule